// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block sits on the controller side of a two-wire bus. A stuck target can hold the data line low. The block frees the bus by playing a fixed line pattern. A single-cycle `go` pulse starts it. The block first makes a Start condition, then gives nine dummy SCL clocks with SDA left released, so that a target caught mid-byte can shift out its remaining bits and let go of the line. It then makes a second Start and a Stop right after it, which leaves every target in its idle state.

The outputs are pull-low enables for open-drain pads. A 1 on `scl_low` or `sda_low` pulls the matching line down, and a 0 lets the external pull-up take the line high. The speed of the pattern is set by `div_val`, which is sampled when the sequence starts. Each line phase lasts `div_val + 1` clock cycles. `busy` stays high for the whole pattern. `done` pulses for one cycle when the pattern ends. The block does not decide when a recovery is needed, and it performs no data transfers.

Top module: `busrec_seq`

## Requirements
- R1: Reset is asynchronous. While `rst_n` is low, and right after it is released, `scl_low`, `sda_low`, `busy` and `done` are all 0. A reset in the middle of a sequence releases both lines at once.
- R2: A `go` pulse seen while idle sets `busy` at the next clock edge. The first phase of the sequence leaves both lines released (`scl_low`=0, `sda_low`=0).
- R3: Every phase of the pattern lasts exactly `div_val + 1` clock cycles, using the `div_val` value sampled with the accepted `go`. A later change on `div_val` does not affect the running sequence.
- R4: After the first Start, exactly nine SCL low pulses begin with SDA released. Each of them lasts one phase.
- R5: SDA never changes in the same cycle as SCL. SDA changes while SCL is released only to form a Start (SDA pulled low) or a Stop (SDA released).
- R6: One sequence contains exactly two Starts and one Stop. The Stop comes exactly one phase after the second Start.
- R7: `busy` stays high for exactly 25 × (`div_val` + 1) cycles. Whenever `busy` is low, both lines are released.
- R8: A `go` pulse that arrives while `busy` is high is ignored. It neither restarts nor extends the sequence, and it is not queued.
- R9: `done` is high for exactly one cycle, in the cycle right after `busy` falls, and only once per sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start request; one-cycle pulse |
| div_val | input | DIV_W | Phase length minus one, in clock cycles |
| scl_low | output | 1 | Pull-low enable for the SCL pad |
| sda_low | output | 1 | Pull-low enable for the SDA pad |
| busy | output | 1 | High while the pattern is being driven |
| done | output | 1 | One-cycle pulse at the end of the pattern |

## Verification
The assertions check the line rules on every cycle:
- SDA never moves together with SCL, and while SCL is released SDA moves only in the Start and Stop steps.
- Both lines stay released when the block is idle.
- The step index holds between divider ticks and never jumps back while busy, which is how an ignored `go` shows up.
- `done` lasts a single cycle.

Other properties need whole-sequence scenarios, which only the bench provides:
- the count of nine dummy clocks,
- the phase length for several divider values,
- the gap between the second Start and the Stop,
- the total busy time,
- the effect of a reset or a second `go` in the middle of a sequence.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

   typedef struct packed {
      logic scl_low;
      logic sda_low;
   } drive_t;

   // Number of pattern steps for a given dummy clock count:
   // idle-high, start, hold, release-sda, 2*n clock phases, idle-high, start, stop
   function automatic int unsigned step_total(input int unsigned n_clk);
      return 4 + 2 * n_clk + 3;
   endfunction

   // Line drive for step idx of the recovery pattern.
   function automatic drive_t step_drive(input int unsigned idx, input int unsigned n_clk);
      drive_t d;
      int unsigned last;
      last = step_total(n_clk) - 1;
      d.scl_low = 1'b0;
      d.sda_low = 1'b0;
      if (idx == 1) begin
         d.sda_low = 1'b1;                      // first start: SDA falls, SCL high
      end else if (idx == 2) begin
         d.scl_low = 1'b1;
         d.sda_low = 1'b1;                      // SCL falls, SDA still low
      end else if (idx == 3) begin
         d.scl_low = 1'b1;                      // SDA released under SCL low
      end else if (idx >= 4 && idx < 4 + 2 * n_clk) begin
         d.scl_low = idx[0];                    // odd steps: SCL low, even: high
      end else if (idx == last - 1) begin
         d.sda_low = 1'b1;                      // second start
      end
      return d;                                 // last step: stop, both released
   endfunction

endpackage

// File: rtl/busrec_divider.sv
module busrec_divider #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_q,
   output logic             tick
);

   generate
      if (DIV_W < 1) begin : g_bad_width
         $error("busrec_divider: DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= div_q)) else $error("phase counter overran divider"); // R3

endmodule

// File: rtl/busrec_stepper.sv
module busrec_stepper #(
   parameter int unsigned N_CLK  = 9,
   parameter int unsigned STEP_W = $clog2(busrec_pkg::step_total(N_CLK))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tick,
   output logic              busy,
   output logic [STEP_W-1:0] step,
   output logic              busy_nxt,
   output logic [STEP_W-1:0] step_nxt,
   output logic              done
);

   localparam int unsigned N_STEPS = busrec_pkg::step_total(N_CLK);
   localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

   generate
      if ((1 << STEP_W) < N_STEPS) begin : g_bad_step_w
         $error("busrec_stepper: STEP_W too narrow for the pattern");
      end
   endgenerate

   logic finish;

   assign finish = busy && tick && (step == LAST);

   always_comb begin
      busy_nxt = busy;
      step_nxt = step;
      if (!busy) begin
         if (start) begin
            busy_nxt = 1'b1;
            step_nxt = '0;
         end
      end else if (tick) begin
         if (step == LAST) begin
            busy_nxt = 1'b0;
            step_nxt = '0;
         end else begin
            step_nxt = step + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         step <= '0;
         done <= 1'b0;
      end else begin
         busy <= busy_nxt;
         step <= step_nxt;
         done <= finish;
      end
   end

   AST_STEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(step)) else $error("step moved without tick"); // R3

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (step >= $past(step))) else $error("sequence restarted"); // R8

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))) else $error("done out of place"); // R9

endmodule

// File: rtl/busrec_drive.sv
module busrec_drive #(
   parameter int unsigned N_CLK  = 9,
   parameter int unsigned STEP_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_nxt,
   input  logic [STEP_W-1:0] step_nxt,
   output logic              scl_low,
   output logic              sda_low
);

   import busrec_pkg::*;

   drive_t drv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv <= '0;
      end else if (busy_nxt) begin
         drv <= step_drive(32'(step_nxt), N_CLK);
      end else begin
         drv <= '0;
      end
   end

   assign scl_low = drv.scl_low;
   assign sda_low = drv.sda_low;

   AST_NO_DUAL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_low != $past(scl_low)) |-> (sda_low == $past(sda_low)))
      else $error("SCL and SDA moved together"); // R5

endmodule

// File: rtl/busrec_seq.sv
module busrec_seq #(
   parameter int unsigned DIV_W = 8,
   parameter int unsigned N_CLK = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [DIV_W-1:0] div_val,
   output logic             scl_low,
   output logic             sda_low,
   output logic             busy,
   output logic             done
);

   localparam int unsigned N_STEPS = busrec_pkg::step_total(N_CLK);
   localparam int unsigned STEP_W  = $clog2(N_STEPS);
   localparam logic [STEP_W-1:0] FIRST_START  = STEP_W'(1);
   localparam logic [STEP_W-1:0] SECOND_START = STEP_W'(N_STEPS - 2);
   localparam logic [STEP_W-1:0] STOP_STEP    = STEP_W'(N_STEPS - 1);

   generate
      if (N_CLK < 1) begin : g_bad_nclk
         $error("busrec_seq: N_CLK must be at least 1");
      end
      if (DIV_W < 1) begin : g_bad_divw
         $error("busrec_seq: DIV_W must be at least 1");
      end
   endgenerate

   logic              start;
   logic              tick;
   logic              busy_nxt;
   logic [STEP_W-1:0] step;
   logic [STEP_W-1:0] step_nxt;
   logic [DIV_W-1:0]  div_q;

   assign start = go && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (start) begin
         div_q <= div_val;
      end
   end

   busrec_divider #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .div_q (div_q),
      .tick  (tick)
   );

   busrec_stepper #(.N_CLK(N_CLK), .STEP_W(STEP_W)) u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .tick     (tick),
      .busy     (busy),
      .step     (step),
      .busy_nxt (busy_nxt),
      .step_nxt (step_nxt),
      .done     (done)
   );

   busrec_drive #(.N_CLK(N_CLK), .STEP_W(STEP_W)) u_drv (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy_nxt (busy_nxt),
      .step_nxt (step_nxt),
      .scl_low  (scl_low),
      .sda_low  (sda_low)
   );

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_low && !sda_low)) else $error("line driven while idle"); // R7

   AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!scl_low && !sda_low)) else $error("first phase not released"); // R2

   AST_SDA_ONLY_AT_COND: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_low && !$past(scl_low) && (sda_low != $past(sda_low))) |->
      (busy && (step == FIRST_START || step == SECOND_START || step == STOP_STEP)))
      else $error("SDA moved under high SCL outside start/stop"); // R5

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R9

endmodule

// File: tb/busrec_seq_bench.sv
module busrec_seq_bench;

   localparam int DIV_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             go = 1'b0;
   logic [DIV_W-1:0] div_val = '0;
   logic             scl_low;
   logic             sda_low;
   logic             busy;
   logic             done;

   always #2 clk = ~clk;

   busrec_seq #(.DIV_W(DIV_W), .N_CLK(9)) u_busrec_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .div_val (div_val),
      .scl_low (scl_low),
      .sda_low (sda_low),
      .busy    (busy),
      .done    (done)
   );

   int n_chk = 0;
   int n_fail = 0;

   // columns: divider, busy cycles, dummy clocks, starts, stops
   localparam int NV = 4;
   localparam int VEC [NV][5] = '{
      '{0,  25, 9, 2, 1},
      '{1,  50, 9, 2, 1},
      '{3, 100, 9, 2, 1},
      '{6, 175, 9, 2, 1}
   };

   // monitor: sole writer of the running totals
   int  mon_p = 1;
   int  cyc = 0, m_busy = 0, m_done = 0, m_clk9 = 0, m_starts = 0, m_stops = 0;
   int  m_len_bad = 0, m_dual = 0, m_gap = 0, last_start = 0, p_begin = 0;
   bit  p_open = 0, pscl = 0, psda = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (busy) m_busy++;
         if (done) m_done++;
         if ((scl_low != pscl) && (sda_low != psda)) m_dual++;
         if (!scl_low && !pscl && (sda_low != psda)) begin
            if (sda_low) begin
               m_starts++;
               last_start = cyc;
            end else begin
               m_stops++;
               m_gap = cyc - last_start;
            end
         end
         if (scl_low && !pscl && !sda_low) begin
            p_open = 1;
            p_begin = cyc;
         end
         if (!scl_low && pscl && p_open) begin
            m_clk9++;
            if (cyc - p_begin != mon_p) m_len_bad++;
            p_open = 0;
         end
         pscl = scl_low;
         psda = sda_low;
      end else begin
         pscl = 0;
         psda = 0;
         p_open = 0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   int s_busy, s_done, s_clk9, s_starts, s_stops, s_len, s_dual;

   task automatic snap();
      s_busy = m_busy; s_done = m_done; s_clk9 = m_clk9; s_starts = m_starts;
      s_stops = m_stops; s_len = m_len_bad; s_dual = m_dual;
   endtask

   task automatic pulse_go(input int div);
      @(negedge clk);
      div_val = DIV_W'(div);
      mon_p = div + 1;
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         #1;
         if (done) break;
      end
      repeat (3) @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!scl_low && !sda_low, "R1 lines in reset", {scl_low, sda_low}, 0);
      chk(!busy && !done, "R1 status in reset", {busy, done}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk(!scl_low && !sda_low && !busy && !done, "R1 after reset", {scl_low, sda_low, busy, done}, 0);

      // vector table over divider values
      for (int v = 0; v < NV; v++) begin
         snap();
         pulse_go(VEC[v][0]);
         #1;
         chk(busy && !scl_low && !sda_low, "R2 first phase", {busy, scl_low, sda_low}, 4);
         wait_done();
         chk(m_busy - s_busy == VEC[v][1], "R7 busy length", m_busy - s_busy, VEC[v][1]);
         chk(m_clk9 - s_clk9 == VEC[v][2], "R4 dummy clocks", m_clk9 - s_clk9, VEC[v][2]);
         chk(m_len_bad == s_len, "R3 phase length", m_len_bad - s_len, 0);
         chk(m_starts - s_starts == VEC[v][3], "R6 starts", m_starts - s_starts, VEC[v][3]);
         chk(m_stops - s_stops == VEC[v][4], "R6 stops", m_stops - s_stops, VEC[v][4]);
         chk(m_gap == VEC[v][0] + 1, "R6 stop gap", m_gap, VEC[v][0] + 1);
         chk(m_dual == s_dual, "R5 joint edges", m_dual - s_dual, 0);
         chk(m_done - s_done == 1, "R9 done count", m_done - s_done, 1);
         chk(!scl_low && !sda_low && !busy, "R7 released at end", {scl_low, sda_low, busy}, 0);
      end

      // R8 + R3: go and divider change while busy
      snap();
      pulse_go(2);
      repeat (30) @(negedge clk);
      div_val = DIV_W'(9);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      wait_done();
      chk(m_busy - s_busy == 75, "R8 busy not extended", m_busy - s_busy, 75);
      chk(m_len_bad == s_len, "R3 divider latched", m_len_bad - s_len, 0);
      chk(m_done - s_done == 1, "R8 single done", m_done - s_done, 1);
      repeat (10) @(negedge clk);
      #1;
      chk(!busy, "R8 go not queued", busy, 0);

      // R1: reset in the middle of the dummy clocks
      pulse_go(4);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         #1;
         if (scl_low && !sda_low) break;
      end
      chk(scl_low, "R1 reached clock phase", scl_low, 1);
      rst_n = 1'b0;
      #1;
      chk(!scl_low && !sda_low && !busy, "R1 async release", {scl_low, sda_low, busy}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      #1;
      chk(!scl_low && !sda_low && !busy && !done, "R1 idle after mid reset", {scl_low, sda_low, busy, done}, 0);

      // R9: done only once after a fresh sequence
      snap();
      pulse_go(0);
      wait_done();
      repeat (5) @(negedge clk);
      chk(m_done - s_done == 1, "R9 done once", m_done - s_done, 1);

      finish_run();
   end

endmodule